// File: doc/BRIEF.md
# Chained Segment FIFO

This block builds one deep first-in first-out queue out of a ring of equal, smaller queue segments. Every segment sees the same write strobe, read strobe, write word and reset. Two ownership tokens travel around the ring. The write token marks the one segment that takes the next write. The read token marks the one segment that supplies the next read. Each token is a single bit per segment. A segment that has just used its last storage location raises an expansion-out pulse, and the next segment in the ring takes the token through its expansion-in input. The last segment links back to the first one.

A first-load input on each segment picks where the tokens start. The segment with first-load low owns both tokens after reset, and every other segment has it high. The top forms the combined empty flag from the segment that holds the read token and the combined full flag from the segment that holds the write token. The read word comes from the read-token segment in first-word fall-through fashion: the oldest word is on the output whenever the queue is not empty.

Replaying data already read is not offered. With a single segment, the ring closes on itself and the block acts as one ordinary FIFO.

Top module: `fifo_chain`

## Requirements
- R1: While reset is low and after its release, `empty` is 1 and `full` is 0. Both `wr_owner` and `rd_owner` equal one-hot bit 0, which is the segment with first-load low.
- R2: Words are read out in the order they were accepted, across segment boundaries and ring wrap-around.
- R3: After SEG_DEPTH accepted writes into one segment, `wr_owner` moves to the next segment, with index (i+1) mod SEG_COUNT. After k accepted writes since reset, `wr_owner` is bit (k / SEG_DEPTH) mod SEG_COUNT.
- R4: `rd_owner` moves to the next segment in the same way after SEG_DEPTH accepted reads. After k accepted reads since reset, it is bit (k / SEG_DEPTH) mod SEG_COUNT.
- R5: `full` is 1 exactly when SEG_COUNT*SEG_DEPTH words are held. A write while `full` is 1 is ignored, and the stored contents stay unchanged.
- R6: `empty` is 1 exactly when no word is held. A read while `empty` is 1 is ignored and does not move the read ownership.
- R7: A read and a write in the same cycle, when neither flag blocks them, are both accepted and leave the occupancy unchanged. At `empty` only the write is accepted. At `full` only the read is accepted.
- R8: Whenever `empty` is 0, `rd_data` shows the oldest held word, with no extra read latency.
- R9: `wr_owner` and `rd_owner` each have exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe shared by all segments |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe shared by all segments |
| rd_data | output | DATA_W | Oldest word, taken from the read-token segment |
| empty | output | 1 | Combined empty flag |
| full | output | 1 | Combined full flag |
| wr_owner | output | SEG_COUNT | One-hot write-token holder |
| rd_owner | output | SEG_COUNT | One-hot read-token holder |

## Verification
The assertions check, on every cycle, the following:
- both tokens stay one-hot;
- a token moves only in a cycle in which its strobe was high;
- a blocked write leaves the queue full;
- a blocked read leaves it empty;
- segment occupancy never goes beyond the segment depth.

Only the bench scenarios can show that word order holds across segment boundaries and ring wrap-around. The same is true of token positions against the count of accepted operations and of the simultaneous read-and-write cases at both flags. The bench shows these by comparing every cycle against a queue model.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

   function automatic int unsigned bits_for(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fifo_chain_seg.sv
module fifo_chain_seg
   import fifo_chain_pkg::*;
#(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned DEPTH  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_load,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              xi_wr,
   input  logic              xi_rd,
   output logic              xo_wr,
   output logic              xo_rd,
   output logic              wr_tok,
   output logic              rd_tok,
   output logic              seg_empty,
   output logic              seg_full,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned PW = bits_for(DEPTH);
   localparam int unsigned CW = bits_for(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   initial begin
      if (DEPTH < 2) $error("segment depth must be at least 2");
      if (DATA_W < 1) $error("data width must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wptr, rptr;
   logic [CW-1:0]     cnt;
   logic              wr_go, rd_go, wr_last, rd_last;

   assign seg_empty = (cnt == '0);
   assign seg_full  = (cnt == CW'(DEPTH));
   assign wr_go     = wr_en & wr_tok & ~seg_full;
   assign rd_go     = rd_en & rd_tok & ~seg_empty;
   assign wr_last   = (wptr == LAST);
   assign rd_last   = (rptr == LAST);
   assign xo_wr     = wr_go & wr_last;
   assign xo_rd     = rd_go & rd_last;
   assign rd_word   = mem[rptr];

   always_ff @(posedge clk) begin
      if (wr_go) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_go) wptr <= wr_last ? '0 : wptr + 1'b1;
         if (rd_go) rptr <= rd_last ? '0 : rptr + 1'b1;
         case ({wr_go, rd_go})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // token flops: expansion-in takes priority so a one-segment ring keeps its tokens
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_tok <= ~first_load;
         rd_tok <= ~first_load;
      end else begin
         if (xi_wr)      wr_tok <= 1'b1;
         else if (xo_wr) wr_tok <= 1'b0;
         if (xi_rd)      rd_tok <= 1'b1;
         else if (xo_rd) rd_tok <= 1'b0;
      end
   end

   // R5
   seg_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

endmodule

// File: rtl/fifo_chain_sel.sv
module fifo_chain_sel #(
   parameter int unsigned N = 3,
   parameter int unsigned W = 10
)(
   input  logic [N-1:0]        sel,
   input  logic [N-1:0][W-1:0] din,
   output logic [W-1:0]        dout
);
   generate
      if (N == 1) begin : g_single
         assign dout = din[0] & {W{sel[0]}};
      end else begin : g_andor
         always_comb begin
            dout = '0;
            for (int i = 0; i < N; i++) dout |= din[i] & {W{sel[i]}};
         end
      end
   endgenerate
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
   import fifo_chain_pkg::*;
#(
   parameter int unsigned DATA_W    = 9,
   parameter int unsigned SEG_DEPTH = 4,
   parameter int unsigned SEG_COUNT = 3
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd_en,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 empty,
   output logic                 full,
   output logic [SEG_COUNT-1:0] wr_owner,
   output logic [SEG_COUNT-1:0] rd_owner
);
   localparam int unsigned RW = DATA_W + 1;

   initial begin
      if (SEG_COUNT < 1) $error("segment count must be at least 1");
   end

   logic [SEG_COUNT-1:0]         xo_wr, xo_rd, seg_empty, seg_full;
   logic [SEG_COUNT-1:0][RW-1:0] rd_pack;
   logic [SEG_COUNT-1:0][0:0]    full_pack;
   logic [RW-1:0]                rd_sel;
   logic [0:0]                   full_sel;

   genvar i;
   generate
      for (i = 0; i < SEG_COUNT; i++) begin : g_seg
         localparam int unsigned PREV = (i + SEG_COUNT - 1) % SEG_COUNT;
         fifo_chain_seg #(.DATA_W(DATA_W), .DEPTH(SEG_DEPTH)) u_seg (
            .clk       (clk),
            .rst_n     (rst_n),
            .first_load(i != 0),
            .wr_en     (wr_en),
            .wr_data   (wr_data),
            .rd_en     (rd_en),
            .xi_wr     (xo_wr[PREV]),
            .xi_rd     (xo_rd[PREV]),
            .xo_wr     (xo_wr[i]),
            .xo_rd     (xo_rd[i]),
            .wr_tok    (wr_owner[i]),
            .rd_tok    (rd_owner[i]),
            .seg_empty (seg_empty[i]),
            .seg_full  (seg_full[i]),
            .rd_word   (rd_pack[i][DATA_W-1:0])
         );
         assign rd_pack[i][DATA_W] = seg_empty[i];
         assign full_pack[i]       = seg_full[i];
      end
   endgenerate

   fifo_chain_sel #(.N(SEG_COUNT), .W(RW)) u_rd_sel (
      .sel (rd_owner),
      .din (rd_pack),
      .dout(rd_sel)
   );

   fifo_chain_sel #(.N(SEG_COUNT), .W(1)) u_full_sel (
      .sel (wr_owner),
      .din (full_pack),
      .dout(full_sel)
   );

   assign empty   = rd_sel[DATA_W];
   assign rd_data = rd_sel[DATA_W-1:0];
   assign full    = full_sel[0];

   // R9
   wr_tok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wr_owner) == 1);
   // R9
   rd_tok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_owner) == 1);
   // R3
   wr_tok_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_owner));
   // R4
   rd_tok_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_owner));
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full);
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_en) |=> empty);

endmodule

// File: tb/fifo_chain_test.sv
module fifo_chain_test;
   localparam int W = 9;
   localparam int D = 4;
   localparam int N = 3;
   localparam int CAP = D * N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic empty, full;
   logic [N-1:0] wr_owner, rd_owner;

   int checks = 0, fails = 0, cycles = 0;
   int wcnt = 0, rcnt = 0;
   logic [W-1:0] q[$];
   logic [W-1:0] seed = 9'h0A5;

   always #2 clk = ~clk;

   fifo_chain #(.DATA_W(W), .SEG_DEPTH(D), .SEG_COUNT(N)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
      .wr_owner(wr_owner), .rd_owner(rd_owner));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [N-1:0] ew, er;
      ew = N'(1) << ((wcnt / D) % N);
      er = N'(1) << ((rcnt / D) % N);
      chk(empty == (q.size() == 0), "R6 empty flag", int'(empty), int'(q.size() == 0));
      chk(full == (q.size() == CAP), "R5 full flag", int'(full), int'(q.size() == CAP));
      chk(wr_owner == ew, "R3 write owner", int'(wr_owner), int'(ew));
      chk(rd_owner == er, "R4 read owner", int'(rd_owner), int'(er));
      chk($countones(wr_owner) == 1 && $countones(rd_owner) == 1, "R9 one-hot",
          int'({wr_owner, rd_owner}), 0);
      if (q.size() != 0)
         chk(rd_data == q[0], "R2 R8 read word", int'(rd_data), int'(q[0]));
   endtask

   // called at negedge: compare, drive, update model for the coming posedge
   task automatic step(input bit w, input bit r);
      bit wa, ra;
      logic [W-1:0] d;
      compare_all();
      seed = {seed[7:0], seed[8] ^ seed[4]};
      d = seed;
      wa = w && (q.size() < CAP);
      ra = r && (q.size() > 0);
      wr_en = w; rd_en = r; wr_data = d;
      if (ra) begin void'(q.pop_front()); rcnt++; end
      if (wa) begin q.push_back(d); wcnt++; end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      int n0;
      @(negedge clk);
      // R1: during reset
      chk(empty === 1'b1 && full === 1'b0, "R1 flags in reset", int'({empty, full}), 2);
      chk(wr_owner === N'(1) && rd_owner === N'(1), "R1 owners in reset",
          int'({wr_owner, rd_owner}), int'({N'(1), N'(1)}));
      rst_n = 1'b1;
      @(negedge clk);
      chk(empty && !full && wr_owner == N'(1) && rd_owner == N'(1), "R1 after release",
          int'({empty, full}), 2);
      // fill, then writes against full (R5)
      for (int k = 0; k < CAP + 3; k++) step(1'b1, 1'b0);
      chk(full && q.size() == CAP, "R5 full after fill", int'(full), 1);
      // R7: read and write at full, only the read is taken
      step(1'b1, 1'b1);
      chk(q.size() == CAP - 1, "R7 at full", q.size(), CAP - 1);
      // drain plus reads against empty (R6)
      for (int k = 0; k < CAP + 3; k++) step(1'b0, 1'b1);
      n0 = rcnt;
      step(1'b0, 1'b1);
      chk(rcnt == n0 && empty, "R6 read ignored", rcnt, n0);
      // R7: read and write at empty, only the write is taken
      step(1'b1, 1'b1);
      chk(q.size() == 1, "R7 at empty", q.size(), 1);
      // R7: steady streaming through several ring laps
      step(1'b1, 1'b0);
      for (int k = 0; k < 40; k++) step(1'b1, 1'b1);
      chk(q.size() == 2, "R7 occupancy held", q.size(), 2);
      // mixed patterns with varying bias
      for (int k = 0; k < 3000; k++) begin
         int b;
         b = (k / 500) % 3;
         step(($urandom % 4) < (b + 1), ($urandom % 4) < (3 - b));
      end
      compare_all();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule